// File: doc/BRIEF.md
# Interrupt Destination Mask Resolver

This block turns the destination fields of an interrupt message into a 256-bit target mask. The mask has one bit per local interrupt controller index. The fields it reads are a destination byte, a physical/logical mode bit, a two-bit shorthand and the sender's own index. For logical addressing it also reads a table with one entry per index: a presence flag, an 8-bit logical destination and a 4-bit addressing model. The delivery stage reads the mask as eight 32-bit words, where index `i` sits in word `i >> 5`, bit `i & 31`.

One strobe on `req_valid` captures the fields into the result register. On the following cycle, `mask_valid` is high and `target_mask` holds the result. A two-state machine tracks the result: `ST_IDLE` means no fresh result and `ST_VALID` means a result was captured on the previous edge. The transitions are:

- `IDLE_TO_VALID`: a strobe arrives while idle.
- `VALID_HOLD`: a strobe arrives while valid.
- `VALID_TO_IDLE`: no strobe arrives while valid.
- `IDLE_STAY`: no strobe arrives while idle.

Broadcast results are not filtered against presence. The downstream delivery stage must drop indices that hold no controller.

The system holds at most 255 controllers, at indices 0 to 254. Index 255 is therefore never picked by logical matching.

Top module: `irq_dest_resolver`

## Requirements
- R1: One cycle after a clock edge that samples `req_valid` high, `mask_valid` is 1. After an edge that samples it low, `mask_valid` is 0 and `target_mask` keeps its previous value, whatever the other inputs do.
- R2: After reset, `mask_valid` is 0 and `target_mask` is all zeros.
- R3: Mask bit `i` is `target_mask[i]`, which is bit `i % 32` of word `i / 32` at `target_mask[32*w+31:32*w]`.
- R4: Shorthand 1 (self) sets only bit `self_id`.
- R5: Shorthand 2 (all including self) sets all 256 bits.
- R6: Shorthand 3 (all excluding self) sets every bit except bit `self_id`.
- R7: Shorthand 0 with `dest_logical`=0 and `dest`=0xFF sets all 256 bits.
- R8: Shorthand 0 with `dest_logical`=0 and `dest`≠0xFF sets only bit `dest`.
- R9: Shorthand 0 with `dest_logical`=1 selects a present index whose model is 4'hF (flat) when `dest & ldest` is nonzero.
- R10: Shorthand 0 with `dest_logical`=1 selects a present index whose model is 4'h0 (cluster) only when the upper nibbles of `dest` and `ldest` are equal and the AND of their lower nibbles is nonzero.
- R11: In logical mode, an index that is absent, or whose model is neither 4'hF nor 4'h0, is never selected.
- R12: In logical mode, bit 255 is never set, even when its presence flag is 1.
- R13: Shorthands 2 and 3 and physical 0xFF set the bits of absent indices too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe; captures the fields below |
| dest | input | 8 | Destination byte |
| dest_logical | input | 1 | 0 = physical, 1 = logical addressing |
| shorthand | input | 2 | 0 none, 1 self, 2 all, 3 all but self |
| self_id | input | 8 | Sender's own index |
| present | input | 256 | Presence flag per index |
| ldest_tbl | input | 2048 | Logical destination per index, entry i at [8i+7:8i] |
| model_tbl | input | 1024 | Addressing model per index, entry i at [4i+3:4i] |
| mask_valid | output | 1 | Result valid (state ST_VALID) |
| target_mask | output | 256 | Target mask, eight 32-bit words |

## Verification
The bench targets the following corner cases:

- **Cluster match with equal upper nibbles but disjoint lower nibbles.** A design that only compared the nibbles would wrongly select the controller.
- **A present index 255 in logical mode.** Without the 255-controller limit, it would show up in the mask.
- **Controllers with an unsupported model value.** A design that treated every non-flat model as cluster would select them.
- **Broadcasts over absent indices.** A design that filtered broadcasts by presence would leave holes in the mask.
- **Self-exclusion at indices 0 and 255.** Off-by-one word/bit mapping would clear the wrong bit.
- **Idle cycles after a result.** These catch a result register that follows the inputs without a strobe.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } rsv_state_e;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;

endpackage

// File: rtl/irq_phys_decode.sv
module irq_phys_decode #(
    parameter int ID_W   = 8,
    parameter int N_CTRL = 1 << ID_W
) (
    input  logic [ID_W-1:0]   dest,
    output logic [N_CTRL-1:0] hits
);
    logic bcast;
    assign bcast = &dest;

    for (genvar i = 0; i < N_CTRL; i++) begin : g_bit
        assign hits[i] = bcast || (dest == ID_W'(i));
    end

    always_comb begin
        if (!bcast)
            assert ($countones(hits) == 1); // R8
    end
endmodule

// File: rtl/irq_logical_match.sv
module irq_logical_match
    import irq_dest_pkg::*;
#(
    parameter int ID_W        = 8,
    parameter int N_CTRL      = 1 << ID_W,
    parameter int MAX_PRESENT = N_CTRL - 1
) (
    input  logic [ID_W-1:0]     dest,
    input  logic [N_CTRL-1:0]   present,
    input  logic [N_CTRL*ID_W-1:0] ldest_tbl,
    input  logic [N_CTRL*4-1:0] model_tbl,
    output logic [N_CTRL-1:0]   hits
);
    localparam int HALF = ID_W / 2;

    for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
        if (i < MAX_PRESENT) begin : g_live
            logic [ID_W-1:0] ld;
            logic [3:0]      mdl;
            logic            flat_hit;
            logic            clus_hit;
            assign ld  = ldest_tbl[i*ID_W +: ID_W];
            assign mdl = model_tbl[i*4 +: 4];
            assign flat_hit = (mdl == MODEL_FLAT) && (|(dest & ld));
            assign clus_hit = (mdl == MODEL_CLUSTER)
                           && (dest[ID_W-1:HALF] == ld[ID_W-1:HALF])
                           && (|(dest[HALF-1:0] & ld[HALF-1:0]));
            assign hits[i] = present[i] && (flat_hit || clus_hit);
        end else begin : g_beyond_cap
            assign hits[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_shorthand_mux.sv
module irq_shorthand_mux
    import irq_dest_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int N_CTRL = 1 << ID_W
) (
    input  shorthand_e        shorthand,
    input  logic              dest_logical,
    input  logic [ID_W-1:0]   self_id,
    input  logic [N_CTRL-1:0] phys_hits,
    input  logic [N_CTRL-1:0] logic_hits,
    output logic [N_CTRL-1:0] next_mask
);
    logic [N_CTRL-1:0] self_oh;

    for (genvar i = 0; i < N_CTRL; i++) begin : g_self
        assign self_oh[i] = (self_id == ID_W'(i));
    end

    always_comb begin
        unique case (shorthand)
            SH_NONE:   next_mask = dest_logical ? logic_hits : phys_hits;
            SH_SELF:   next_mask = self_oh;
            SH_ALL:    next_mask = '1;
            SH_OTHERS: next_mask = ~self_oh;
            default:   next_mask = '0;
        endcase
    end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
    import irq_dest_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int WORD_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ID_W-1:0]             dest,
    input  logic                        dest_logical,
    input  logic [1:0]                  shorthand,
    input  logic [ID_W-1:0]             self_id,
    input  logic [(1<<ID_W)-1:0]        present,
    input  logic [(1<<ID_W)*ID_W-1:0]   ldest_tbl,
    input  logic [(1<<ID_W)*4-1:0]      model_tbl,
    output logic                        mask_valid,
    output logic [(1<<ID_W)-1:0]        target_mask
);
    localparam int N_CTRL      = 1 << ID_W;
    localparam int N_WORDS     = N_CTRL / WORD_W;
    localparam int MAX_PRESENT = N_CTRL - 1;

    logic [N_CTRL-1:0] phys_hits;
    logic [N_CTRL-1:0] logic_hits;
    logic [N_CTRL-1:0] next_mask;
    logic [N_CTRL-1:0] mask_q;
    rsv_state_e        state_q, state_d;
    shorthand_e        sh;

    assign sh = shorthand_e'(shorthand);

    irq_phys_decode #(.ID_W(ID_W), .N_CTRL(N_CTRL)) u_phys (
        .dest (dest),
        .hits (phys_hits)
    );

    irq_logical_match #(.ID_W(ID_W), .N_CTRL(N_CTRL), .MAX_PRESENT(MAX_PRESENT)) u_logic (
        .dest      (dest),
        .present   (present),
        .ldest_tbl (ldest_tbl),
        .model_tbl (model_tbl),
        .hits      (logic_hits)
    );

    irq_shorthand_mux #(.ID_W(ID_W), .N_CTRL(N_CTRL)) u_mux (
        .shorthand    (sh),
        .dest_logical (dest_logical),
        .self_id      (self_id),
        .phys_hits    (phys_hits),
        .logic_hits   (logic_hits),
        .next_mask    (next_mask)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = req_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result register: loads only on a strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= '0;
        else if (req_valid) mask_q <= next_mask;
    end

    assign mask_valid = (state_q == ST_VALID);

    // word-organised view: word w occupies bits [WORD_W*w +: WORD_W]
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        assign target_mask[w*WORD_W +: WORD_W] = mask_q[w*WORD_W +: WORD_W];
    end

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> mask_valid); // R1
    AST_IDLE_HOLDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!mask_valid && $stable(target_mask))); // R1
    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sh == SH_SELF) |=>
            ($countones(target_mask) == 1 && target_mask[$past(self_id)])); // R4
    AST_OTHERS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sh == SH_OTHERS) |=>
            ($countones(target_mask) == N_CTRL-1 && !target_mask[$past(self_id)])); // R6
    AST_PHYS_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sh == SH_NONE && !dest_logical && &dest) |=> (&target_mask)); // R7
    AST_CAP_LOGICAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sh == SH_NONE && dest_logical) |=> !target_mask[N_CTRL-1]); // R12
endmodule

// File: tb/irq_dest_resolver_tb.sv
`timescale 1ns/1ps
module irq_dest_resolver_tb;
    localparam int N = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [7:0]    dest = '0;
    logic          dest_logical = 1'b0;
    logic [1:0]    shorthand = '0;
    logic [7:0]    self_id = '0;
    logic [N-1:0]  present = '0;
    logic [N*8-1:0] ldest_tbl = '0;
    logic [N*4-1:0] model_tbl = '0;
    logic          mask_valid;
    logic [N-1:0]  target_mask;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_dest_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dest(dest),
        .dest_logical(dest_logical), .shorthand(shorthand), .self_id(self_id),
        .present(present), .ldest_tbl(ldest_tbl), .model_tbl(model_tbl),
        .mask_valid(mask_valid), .target_mask(target_mask)
    );

    function automatic logic [N-1:0] ref_mask(input logic [7:0] d, input logic lg,
                                              input logic [1:0] sh, input logic [7:0] sid);
        logic [N-1:0] m = '0;
        case (sh)
            2'd1: m[sid] = 1'b1;
            2'd2: m = '1;
            2'd3: begin m = '1; m[sid] = 1'b0; end
            default: begin
                if (!lg) begin
                    if (d == 8'hFF) m = '1; else m[d] = 1'b1;
                end else begin
                    for (int i = 0; i < N - 1; i++) begin
                        logic [7:0] ld = ldest_tbl[i*8 +: 8];
                        logic [3:0] md = model_tbl[i*4 +: 4];
                        if (present[i] && md == 4'hF && (d & ld) != 8'h00) m[i] = 1'b1;
                        if (present[i] && md == 4'h0 && d[7:4] == ld[7:4]
                            && (d[3:0] & ld[3:0]) != 4'h0) m[i] = 1'b1;
                    end
                end
            end
        endcase
        return m;
    endfunction

    function automatic string tag_of(input logic lg, input logic [1:0] sh, input logic [7:0] d);
        case (sh)
            2'd1: return "R4";
            2'd2: return "R5/R13";
            2'd3: return "R6/R13";
            default: if (lg) return "R9/R10/R11/R12";
                     else if (d == 8'hFF) return "R7";
                     else return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge; result appears after next posedge, sampled at following negedge
    task automatic request(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                           input logic [7:0] sid, input bit check_hold);
        logic [N-1:0] exp;
        string tg;
        exp = ref_mask(d, lg, sh, sid);
        tg = tag_of(lg, sh, d);
        dest = d; dest_logical = lg; shorthand = sh; self_id = sid; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(mask_valid === 1'b1, "R1 valid", {255'd0, mask_valid}, {255'd0, 1'b1});
        check(target_mask === exp, tg, target_mask, exp);
        if (check_hold) begin
            dest = ~d; shorthand = 2'd2; dest_logical = ~lg;
            @(negedge clk);
            check(mask_valid === 1'b0 && target_mask === exp, "R1 hold",
                  target_mask, exp);
        end
    endtask

    task automatic random_config();
        for (int i = 0; i < N; i++) begin
            int r = $urandom % 4;
            present[i] = ($urandom % 4) != 0;
            ldest_tbl[i*8 +: 8] = {4'($urandom % 3), 4'($urandom)};
            model_tbl[i*4 +: 4] = (r == 0) ? 4'h0 : (r == 1) ? 4'hF : 4'($urandom);
        end
        present[N-1] = 1'b1;
        model_tbl[(N-1)*4 +: 4] = 4'hF;
        ldest_tbl[(N-1)*8 +: 8] = 8'hFF;
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        check(mask_valid === 1'b0 && target_mask === '0, "R2 reset", target_mask, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: word layout (R3), idx 0x45 -> word 2 bit 5
        request(8'h45, 1'b0, 2'd0, 8'h00, 1'b1);
        check(target_mask[2*32 +: 32] === 32'h0000_0020, "R3 word layout",
              {224'd0, target_mask[2*32 +: 32]}, {224'd0, 32'h20});
        // self-exclusion at edges, broadcasts over absent indices (present all 0)
        request(8'h00, 1'b0, 2'd3, 8'h00, 1'b0);
        request(8'h00, 1'b0, 2'd3, 8'hFF, 1'b0);
        request(8'h00, 1'b0, 2'd1, 8'hFF, 1'b0);
        request(8'h00, 1'b0, 2'd2, 8'h07, 1'b0);
        request(8'hFF, 1'b0, 2'd0, 8'h07, 1'b1);

        // directed logical corners
        present = '0;
        present[3] = 1'b1; ldest_tbl[3*8 +: 8] = 8'h21; model_tbl[3*4 +: 4] = 4'h0; // R10 disjoint low
        present[4] = 1'b1; ldest_tbl[4*8 +: 8] = 8'h22; model_tbl[4*4 +: 4] = 4'h0; // R10 hit
        present[5] = 1'b1; ldest_tbl[5*8 +: 8] = 8'h32; model_tbl[5*4 +: 4] = 4'h0; // R10 other cluster
        present[10] = 1'b1; ldest_tbl[10*8 +: 8] = 8'hFF; model_tbl[10*4 +: 4] = 4'h5; // R11 bad model
        ldest_tbl[11*8 +: 8] = 8'hFF; model_tbl[11*4 +: 4] = 4'hF;                   // R11 absent
        present[12] = 1'b1; ldest_tbl[12*8 +: 8] = 8'h02; model_tbl[12*4 +: 4] = 4'hF; // R9 hit
        present[255] = 1'b1; ldest_tbl[255*8 +: 8] = 8'hFF; model_tbl[255*4 +: 4] = 4'hF; // R12
        request(8'h22, 1'b1, 2'd0, 8'h00, 1'b1);
        check(target_mask[4] && !target_mask[3] && !target_mask[5], "R10 cluster",
              target_mask, ref_mask(8'h22, 1'b1, 2'd0, 8'h00));
        check(!target_mask[10] && !target_mask[11] && target_mask[12], "R11/R9",
              target_mask, ref_mask(8'h22, 1'b1, 2'd0, 8'h00));
        check(!target_mask[255], "R12 cap", target_mask, ref_mask(8'h22, 1'b1, 2'd0, 8'h00));

        // constrained random
        for (int k = 0; k < 40; k++) begin
            random_config();
            for (int j = 0; j < 8; j++) begin
                logic [1:0] sh = ($urandom % 2) ? 2'd0 : 2'($urandom);
                logic [7:0] d = ($urandom % 8 == 0) ? 8'hFF : {4'($urandom % 3), 4'($urandom)};
                request(d, 1'($urandom), sh, 8'($urandom), ($urandom % 4) == 0);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule